// File: doc/BRIEF.md
# Atomic Trace Selection Builder

This block watches a stream of retired, decoded micro-operations, one per accepted beat, and cuts it into atomic traces under fixed rules. Each beat carries the uop address, a flag marking the last uop of a basic block, a control-transfer kind, and, for conditional branches, the direction and the target address. The block keeps only counters for the basic block in progress and for the trace in progress. It never stores uops. When a trace closes it emits one descriptor: the start address, the uop count, the number of conditional branches, the packed branch outcomes, and a flag for a forced split.

Traces are built only from whole basic blocks, up to a fixed capacity. A trace ends after an indirect jump, after a software exception, or after a conditional branch taken backward. Calls and returns only end a basic block, so a called procedure is inlined into the trace. If a basic block does not fit in the open trace, the open trace is closed and that block starts the next one. The input side and the descriptor side are both valid/ready streams.

Top module: `trace_select_builder`

## Requirements
- R1: A synchronous reset (rst high) clears the partial trace and the open basic block, and out_valid is low after reset. The first uop accepted after reset gives the start address of the next descriptor.
- R2: The uop kind encoding is 0 plain, 1 conditional branch, 2 indirect jump, 3 call, 4 return, 5 software exception. A nonzero kind or in_bb_end ends a basic block. Blocks that end in plain, call or return uops stay in the open trace.
- R3: An indirect jump closes the trace, and the jump is counted as the trace's last uop.
- R4: A software exception closes the trace, and the exception uop is counted in it.
- R5: A conditional branch that is taken with in_target at or below in_addr closes the trace. A not-taken branch does not close it, and neither does a branch taken to a higher address.
- R6: A trace holds at most MAX_UOPS (64) uops. If a completed basic block would push the open trace past that limit, the open trace is emitted first and the block starts a new trace. A basic block of 64 or fewer uops is never divided.
- R7: A basic block longer than 64 uops is cut after its 64th uop. The cut piece is emitted as its own descriptor with out_split=1 and out_count=64. The remaining uops start a new block.
- R8: Bit i of out_bits holds the outcome (1 = taken) of the i-th conditional branch of the trace in program order, and out_nbr gives how many such bits are valid, up to 16. A block whose conditional branch would be the 17th closes the open trace before that block.
- R9: While out_valid is high and out_ready is low, in_ready is low and the descriptor holds steady. Under backpressure no uop is lost and no descriptor is dropped or repeated.
- R10: Every descriptor has an out_count from 1 to 64 on the 7-bit field, and the out_bits positions at or above out_nbr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Uop beat valid |
| in_ready | output | 1 | Block can accept a uop |
| in_addr | input | AW | Uop address |
| in_bb_end | input | 1 | Uop is the last of its basic block |
| in_kind | input | 3 | Control-transfer kind (see R2) |
| in_taken | input | 1 | Conditional branch was taken |
| in_target | input | AW | Branch target address |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer accepts the descriptor |
| out_start | output | AW | Address of the first uop of the trace |
| out_count | output | 7 | Uop count, 1 to 64 |
| out_nbr | output | 5 | Number of conditional branches |
| out_bits | output | 16 | Branch outcomes, bit i = i-th branch |
| out_split | output | 1 | Trace is a piece cut from an oversized block |

## Verification
The properties assume that the consumer never withdraws a descriptor it has not yet accepted. They also assume that in_taken and in_target mean something only on conditional-branch beats. The bench drives out_ready from a pseudo-random sequence that changes only between edges, and it keeps each uop steady until it has been accepted. The same program of traces is replayed with and without backpressure, so every closing rule is tested with the output both free and stalled.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
   typedef enum logic [2:0] {
      K_PLAIN = 3'd0,
      K_COND  = 3'd1,
      K_INDIR = 3'd2,
      K_CALL  = 3'd3,
      K_RET   = 3'd4,
      K_EXC   = 3'd5
   } uop_kind_e;
endpackage

// File: rtl/tsel_classify.sv
module tsel_classify
   import tsel_pkg::*;
#(
   parameter int AW = 32,
   parameter bit BACK_INCLUSIVE = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] target,
   input  logic [2:0]    kind,
   input  logic          taken,
   input  logic          bb_end,
   output logic          is_cond,
   output logic          outcome,
   output logic          blk_end,
   output logic          term
);
   uop_kind_e k;
   logic      back;

   assign k       = uop_kind_e'(kind);
   assign is_cond = (k == K_COND);
   assign outcome = is_cond && taken;
   assign blk_end = bb_end || (k != K_PLAIN);

   // R5: backward-taken compare, target equal to address counts as backward by default
   generate
      if (BACK_INCLUSIVE) begin : g_le
         assign back = outcome && (target <= addr);
      end else begin : g_lt
         assign back = outcome && (target < addr);
      end
   endgenerate

   assign term = (k == K_INDIR) || (k == K_EXC) || back;
endmodule

// File: rtl/tsel_block.sv
module tsel_block #(
   parameter int AW       = 32,
   parameter int MAX_UOPS = 64,
   parameter int CW       = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          accept,
   input  logic [AW-1:0] addr,
   input  logic          blk_end,
   output logic          done,
   output logic          cut,
   output logic [CW-1:0] len,
   output logic [AW-1:0] start
);
   logic [CW-1:0] pend_cnt;
   logic [AW-1:0] pend_start;

   assign cut   = !blk_end && (pend_cnt == CW'(MAX_UOPS - 1));
   assign done  = blk_end || cut;
   assign len   = pend_cnt + CW'(1);
   assign start = (pend_cnt == '0) ? addr : pend_start;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_cnt   <= '0;
         pend_start <= '0;
      end else if (accept) begin
         if (done) begin
            pend_cnt <= '0;
         end else begin
            pend_cnt <= pend_cnt + CW'(1);
            if (pend_cnt == '0) pend_start <= addr;
         end
      end
   end
endmodule

// File: rtl/tsel_trace.sv
module tsel_trace #(
   parameter int AW       = 32,
   parameter int MAX_UOPS = 64,
   parameter int MAX_BR   = 16,
   parameter int CW       = 7,
   parameter int BW       = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              blk_fire,
   input  logic [CW-1:0]     blk_len,
   input  logic [AW-1:0]     blk_start,
   input  logic              blk_cond,
   input  logic              blk_taken,
   input  logic              blk_term,
   input  logic              blk_cut,
   output logic              slot_ok,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [AW-1:0]     out_start,
   output logic [CW-1:0]     out_count,
   output logic [BW-1:0]     out_nbr,
   output logic [MAX_BR-1:0] out_bits,
   output logic              out_split
);
   typedef struct packed {
      logic [AW-1:0]     start;
      logic [CW-1:0]     cnt;
      logic [BW-1:0]     nbr;
      logic [MAX_BR-1:0] bits;
      logic              split;
   } desc_t;

   desc_t tr, od, m;
   logic  ov, hold, slot_free, over, close_now;
   logic [CW:0]       sum;
   logic [CW-1:0]     base_cnt;
   logic [BW-1:0]     base_nbr;
   logic [MAX_BR-1:0] base_bits;

   assign slot_free = !ov || out_ready;
   assign slot_ok   = !hold && slot_free;
   assign sum       = {1'b0, tr.cnt} + {1'b0, blk_len};
   assign over      = (tr.cnt != '0) &&
                      ((sum > (CW+1)'(MAX_UOPS)) || (blk_cond && tr.nbr == BW'(MAX_BR)));
   assign close_now = blk_term || blk_cut;

   assign base_cnt  = over ? '0 : tr.cnt;
   assign base_nbr  = over ? '0 : tr.nbr;
   assign base_bits = over ? '0 : tr.bits;

   assign m.start = (over || tr.cnt == '0) ? blk_start : tr.start;
   assign m.cnt   = base_cnt + blk_len;
   assign m.nbr   = base_nbr + BW'(blk_cond);
   assign m.split = blk_cut;

   generate
      for (genvar i = 0; i < MAX_BR; i++) begin : g_bit
         assign m.bits[i] = (blk_cond && base_nbr == BW'(i)) ? blk_taken : base_bits[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         tr   <= '0;
         od   <= '0;
         ov   <= 1'b0;
         hold <= 1'b0;
      end else begin
         if (ov && out_ready) ov <= 1'b0;
         if (hold && slot_free) begin
            od   <= tr;
            ov   <= 1'b1;
            tr   <= '0;
            hold <= 1'b0;
         end else if (blk_fire) begin
            if (over) begin
               od   <= tr;
               ov   <= 1'b1;
               tr   <= m;
               hold <= close_now;
            end else if (close_now) begin
               od <= m;
               ov <= 1'b1;
               tr <= '0;
            end else begin
               tr <= m;
            end
         end
      end
   end

   assign out_valid = ov;
   assign out_start = od.start;
   assign out_count = od.cnt;
   assign out_nbr   = od.nbr;
   assign out_bits  = od.bits;
   assign out_split = od.split;
endmodule

// File: rtl/trace_select_builder.sv
module trace_select_builder #(
   parameter int  AW             = 32,
   parameter int  MAX_UOPS       = 64,
   parameter int  MAX_BR         = 16,
   parameter bit  BACK_INCLUSIVE = 1'b1,
   localparam int CW             = $clog2(MAX_UOPS + 1),
   localparam int BW             = $clog2(MAX_BR + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [AW-1:0]     in_addr,
   input  logic              in_bb_end,
   input  logic [2:0]        in_kind,
   input  logic              in_taken,
   input  logic [AW-1:0]     in_target,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [AW-1:0]     out_start,
   output logic [CW-1:0]     out_count,
   output logic [BW-1:0]     out_nbr,
   output logic [MAX_BR-1:0] out_bits,
   output logic              out_split
);
   generate
      if (MAX_UOPS < 2) begin : g_bad_uops
         $error("MAX_UOPS must be at least 2");
      end
      if (MAX_BR < 1) begin : g_bad_br
         $error("MAX_BR must be at least 1");
      end
      if (AW < 2) begin : g_bad_aw
         $error("AW must be at least 2");
      end
   endgenerate

   logic          accept, is_cond, outcome, blk_end, term, done, cut;
   logic [CW-1:0] len;
   logic [AW-1:0] bstart;

   assign accept = in_valid && in_ready;

   tsel_classify #(.AW(AW), .BACK_INCLUSIVE(BACK_INCLUSIVE)) u_cls (
      .addr(in_addr), .target(in_target), .kind(in_kind), .taken(in_taken),
      .bb_end(in_bb_end), .is_cond(is_cond), .outcome(outcome),
      .blk_end(blk_end), .term(term)
   );

   tsel_block #(.AW(AW), .MAX_UOPS(MAX_UOPS), .CW(CW)) u_blk (
      .clk(clk), .rst(rst), .accept(accept), .addr(in_addr), .blk_end(blk_end),
      .done(done), .cut(cut), .len(len), .start(bstart)
   );

   tsel_trace #(.AW(AW), .MAX_UOPS(MAX_UOPS), .MAX_BR(MAX_BR), .CW(CW), .BW(BW)) u_trc (
      .clk(clk), .rst(rst), .blk_fire(accept && done), .blk_len(len),
      .blk_start(bstart), .blk_cond(is_cond), .blk_taken(outcome),
      .blk_term(term), .blk_cut(cut), .slot_ok(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
      .out_count(out_count), .out_nbr(out_nbr), .out_bits(out_bits),
      .out_split(out_split)
   );
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
   parameter int AW       = 32,
   parameter int MAX_UOPS = 64,
   parameter int MAX_BR   = 16,
   parameter int CW       = 7,
   parameter int BW       = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [AW-1:0]     out_start,
   input logic [CW-1:0]     out_count,
   input logic [BW-1:0]     out_nbr,
   input logic [MAX_BR-1:0] out_bits,
   input logic              out_split
);
   p_idle_after_reset_r1: assert property (@(posedge clk)
      rst |=> !out_valid);

   p_count_range_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_count >= CW'(1)) && (out_count <= CW'(MAX_UOPS)));

   p_bits_clean_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_nbr <= BW'(MAX_BR)) && ((out_bits >> out_nbr) == '0));

   p_split_full_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_split) |-> (out_count == CW'(MAX_UOPS)));

   p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   p_desc_held_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> out_valid && $stable(out_start) && $stable(out_count)
         && $stable(out_nbr) && $stable(out_bits) && $stable(out_split));
endmodule

bind trace_select_builder tsel_checker #(
   .AW(AW), .MAX_UOPS(MAX_UOPS), .MAX_BR(MAX_BR), .CW(CW), .BW(BW)
) u_chk (
   .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_start(out_start), .out_count(out_count),
   .out_nbr(out_nbr), .out_bits(out_bits), .out_split(out_split)
);

// File: tb/sim_trace_select_builder.sv
module sim_trace_select_builder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0, in_bb_end = 1'b0, in_taken = 1'b0;
   logic [31:0] in_addr = '0, in_target = '0;
   logic [2:0]  in_kind = '0;
   logic        out_ready = 1'b1;
   logic        in_ready, out_valid, out_split;
   logic [31:0] out_start;
   logic [6:0]  out_count;
   logic [4:0]  out_nbr;
   logic [15:0] out_bits;

   int checks = 0, errors = 0;
   bit throttle = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] pc = 32'h1000;

   typedef struct {
      logic [31:0] st;
      int          cnt;
      int          nbr;
      logic [15:0] bits;
      logic        split;
      string       tag;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   trace_select_builder u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_bb_end(in_bb_end), .in_kind(in_kind),
      .in_taken(in_taken), .in_target(in_target), .out_valid(out_valid),
      .out_ready(out_ready), .out_start(out_start), .out_count(out_count),
      .out_nbr(out_nbr), .out_bits(out_bits), .out_split(out_split)
   );

   always @(posedge clk) begin
      #1;
      if (throttle) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = lfsr[0];
      end else begin
         out_ready = 1'b1;
      end
   end

   // monitor: pops the scoreboard on every descriptor handshake
   always @(negedge clk) begin
      if (!rst) begin
         if (out_valid && !out_ready) begin
            checks++;
            if (in_ready) begin
               errors++;
               $display("FAIL R9: in_ready=%b while stalled, expected 0", in_ready);
            end
         end
         if (out_valid && out_ready) begin
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R9: unexpected descriptor start=%h count=%0d, expected none",
                        out_start, out_count);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (out_start !== e.st || int'(out_count) != e.cnt || int'(out_nbr) != e.nbr ||
                   out_bits !== e.bits || out_split !== e.split) begin
                  errors++;
                  $display("FAIL %s: got start=%h count=%0d nbr=%0d bits=%h split=%b, expected start=%h count=%0d nbr=%0d bits=%h split=%b",
                           e.tag, out_start, out_count, out_nbr, out_bits, out_split,
                           e.st, e.cnt, e.nbr, e.bits, e.split);
               end
            end
         end
      end
   end

   task automatic expect_d(logic [31:0] st, int cnt, int nbr, logic [15:0] bits,
                           logic split, string tag);
      exp_t e;
      e.st = st; e.cnt = cnt; e.nbr = nbr; e.bits = bits; e.split = split; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic send_uop(logic [31:0] a, logic e, logic [2:0] k, logic t, logic [31:0] tg);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a; in_bb_end = e; in_kind = k; in_taken = t; in_target = tg;
      forever begin
         #1;
         if (in_ready) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   // tmode: 0 target above, 1 target below, 2 target equal to the branch address
   task automatic send_block(int len, logic [2:0] k, logic t, int tmode);
      for (int i = 0; i < len; i++) begin
         logic        last;
         logic [31:0] tg;
         last = (i == len - 1);
         tg = (tmode == 0) ? pc + 32'd16 : (tmode == 1) ? pc - 32'd8 : pc;
         send_uop(pc, last, last ? k : 3'd0, last ? t : 1'b0, tg);
         pc += 32'd4;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain(string tag);
      for (int i = 0; i < 3000 && q.size() > 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      checks++;
      if (q.size() != 0 || out_valid) begin
         errors++;
         $display("FAIL %s: %0d descriptors missing, out_valid=%b, expected 0 and 0",
                  tag, q.size(), out_valid);
         q.delete();
      end
   endtask

   task automatic run_seq();
      logic [31:0] s;
      // R2 + R3: plain and return blocks inline, indirect jump closes
      s = pc;
      expect_d(s, 12, 0, 16'h0, 1'b0, "R3");
      send_block(5, 3'd0, 1'b0, 0);
      send_block(3, 3'd4, 1'b0, 0);
      send_block(4, 3'd2, 1'b0, 0);
      // R2: call does not close either
      s = pc;
      expect_d(s, 4, 0, 16'h0, 1'b0, "R2");
      send_block(2, 3'd3, 1'b0, 0);
      send_block(2, 3'd2, 1'b0, 0);
      // R5 + R8: not-taken, forward taken, backward taken
      s = pc;
      expect_d(s, 7, 3, 16'b110, 1'b0, "R5");
      send_block(2, 3'd1, 1'b0, 0);
      send_block(3, 3'd1, 1'b1, 0);
      send_block(2, 3'd1, 1'b1, 1);
      // R5: target equal to own address counts as backward
      s = pc;
      expect_d(s, 1, 1, 16'b1, 1'b0, "R5");
      send_block(1, 3'd1, 1'b1, 2);
      // R4: exception closes
      s = pc;
      expect_d(s, 6, 0, 16'h0, 1'b0, "R4");
      send_block(6, 3'd5, 1'b0, 0);
      // R6: overflow closes before the block, which then terminates too
      s = pc;
      expect_d(s, 60, 0, 16'h0, 1'b0, "R6");
      expect_d(s + 32'd240, 10, 0, 16'h0, 1'b0, "R6");
      send_block(30, 3'd0, 1'b0, 0);
      send_block(30, 3'd0, 1'b0, 0);
      send_block(10, 3'd2, 1'b0, 0);
      // R6: exact fit of 64
      s = pc;
      expect_d(s, 64, 0, 16'h0, 1'b0, "R6");
      send_block(40, 3'd0, 1'b0, 0);
      send_block(24, 3'd2, 1'b0, 0);
      // R7: oversized block cut at 64
      s = pc;
      expect_d(s, 5, 0, 16'h0, 1'b0, "R7");
      expect_d(s + 32'd20, 64, 0, 16'h0, 1'b1, "R7");
      expect_d(s + 32'd276, 6, 0, 16'h0, 1'b0, "R7");
      send_block(5, 3'd0, 1'b0, 0);
      send_block(70, 3'd2, 1'b0, 0);
      // R8: 17th branch closes the trace before its block
      s = pc;
      expect_d(s, 16, 16, 16'hAAAA, 1'b0, "R8");
      expect_d(s + 32'd64, 2, 1, 16'h0, 1'b0, "R8");
      for (int i = 0; i < 17; i++) send_block(1, 3'd1, logic'(i % 2), 0);
      send_block(1, 3'd2, 1'b0, 0);
      idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: out_valid=%b in reset, expected 0", out_valid);
      end
      rst = 1'b0;

      throttle = 1'b0;
      run_seq();
      drain("R6");
      throttle = 1'b1;
      run_seq();
      drain("R9");
      throttle = 1'b0;

      // R1: reset discards a partial trace
      send_block(3, 3'd0, 1'b0, 0);
      idle();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: out_valid=%b after reset, expected 0", out_valid);
      end
      rst = 1'b0;
      expect_d(pc, 2, 0, 16'h0, 1'b0, "R1");
      send_block(2, 3'd2, 1'b0, 0);
      idle();
      drain("R1");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule